// File: doc/BRIEF.md
# Three-Level Address Translation Walker

This block turns a 32-bit linear address into a 36-bit physical address by reading a three-level set of translation tables from memory. The first level is a small four-entry root table found through a base value. The second is a 512-entry directory. The third is a 512-entry leaf table. All entries are 64 bits wide. A directory entry may instead map a 2 MB region directly, and in that case the walk ends one level early.

A client hands over one linear address through a valid/ready handshake. The walker then issues one read per level on a single-outstanding memory port. It finishes with either a one-cycle completion pulse carrying the physical address, or a one-cycle fault pulse that names the level whose entry was not present. When translation is switched off, a request is still accepted, but it is answered with an error pulse and no memory traffic.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_req_valid`, `done`, `fault` and `err` are all 0.
- R2: The first read goes to byte address `tbl_base * 32 + lin[31:30] * 8`. `tbl_base` and `xlat_en` are sampled when the request is accepted.
- R3: The second read goes to `F * 4096 + lin[29:21] * 8`, where F is bits 35..12 of the root entry.
- R4: For a 4 KB mapping, the third read goes to `F * 4096 + lin[20:12] * 8`, where F is bits 35..12 of the directory entry.
- R5: A 4 KB walk completes with `pa = {leaf[35:12], lin[11:0]}`. Entry bits 63..36 and all flag bits other than bit 0 and bit 7 have no effect on the result.
- R6: When bit 7 of a present directory entry is 1, the walk ends after two reads with `pa = {dir[35:21], lin[20:0]}`. Bit 7 of root and leaf entries is ignored.
- R7: An entry whose bit 0 is clear ends the walk with `fault`, and `fault_lvl` gives the level: 0 for root, 1 for directory, 2 for leaf. No further read is issued.
- R8: A request accepted while `xlat_en` is 0 produces `err` in the cycle after acceptance and issues no memory read.
- R9: `done`, `fault` and `err` are single-cycle pulses, at most one of them is high in any cycle, and `req_ready` is 0 for the whole walk.
- R10: While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays asserted with an unchanged address. Exactly one read is issued per level visited.
- R11: In the cycle a result pulse is driven, `req_ready` is already 1, so a waiting request is accepted at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlat_en | input | 1 | Translation enable, sampled on request acceptance |
| tbl_base | input | 27 | Root table locator, in units of 32 bytes |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_lin | input | 32 | Linear address to translate |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the 64-bit entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | Translation complete (one cycle) |
| pa | output | 36 | Physical address, valid with `done` |
| fault | output | 1 | Entry not present (one cycle) |
| fault_lvl | output | 2 | Level of the missing entry, valid with `fault` |
| err | output | 1 | Request rejected because translation is off (one cycle) |

## Verification
Two things can happen in the same cycle: the result pulse of one walk and the acceptance of the next queued request. The bench provokes this by holding a second request on `req_valid` while the first walk is still running. The scoreboard then expects both responses in order, and it checks that `req_ready` is high in every cycle that carries a result pulse. The same scoreboard also checks every issued address against a table walk the bench computes itself, including runs in which the memory withholds `mem_req_ready` so that address holding can be judged.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int LIN_W   = 32;
  localparam int PA_W    = 36;
  localparam int ENT_W   = 64;
  localparam int PG_SH   = 12;
  localparam int BIG_SH  = 21;
  localparam int IDX_W   = 9;
  localparam int TOP_W   = LIN_W - BIG_SH - IDX_W;
  localparam int ENT_SH  = 3;
  localparam int BASE_SH = 5;
  localparam int BASE_W  = 27;
  localparam int FRM_W   = PA_W - PG_SH;
  localparam int PRES_BIT = 0;
  localparam int SIZE_BIT = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} walk_st_e;
  typedef enum logic [1:0] {LV_ROOT = 2'd0, LV_DIR = 2'd1, LV_LEAF = 2'd2} walk_lv_e;

  function automatic logic [PA_W-1:0] root_entry_addr(
    input logic [BASE_W-1:0] base, input logic [TOP_W-1:0] idx);
    return (PA_W'(base) << BASE_SH) + (PA_W'(idx) << ENT_SH);
  endfunction

  function automatic logic [PA_W-1:0] child_entry_addr(
    input logic [FRM_W-1:0] frame, input logic [IDX_W-1:0] idx);
    return (PA_W'(frame) << PG_SH) + (PA_W'(idx) << ENT_SH);
  endfunction

  function automatic logic [PA_W-1:0] small_page_pa(
    input logic [FRM_W-1:0] frame, input logic [PG_SH-1:0] ofs);
    return {frame, ofs};
  endfunction

  function automatic logic [PA_W-1:0] big_page_pa(
    input logic [FRM_W-1:0] frame, input logic [BIG_SH-1:0] ofs);
    return {frame[FRM_W-1:BIG_SH-PG_SH], ofs};
  endfunction
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
  import xlat_pkg::*;
(
  input  walk_lv_e            lvl,
  input  logic [BASE_W-1:0]   base,
  input  logic [FRM_W-1:0]    frame,
  input  logic [LIN_W-1:0]    lin,
  output logic [PA_W-1:0]     addr
);
  logic [TOP_W-1:0] root_idx;
  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] leaf_idx;
  logic [PG_SH-1:0] unused_ofs;

  assign root_idx   = lin[LIN_W-1 -: TOP_W];
  assign dir_idx    = lin[BIG_SH +: IDX_W];
  assign leaf_idx   = lin[PG_SH +: IDX_W];
  assign unused_ofs = lin[PG_SH-1:0];

  always_comb begin
    case (lvl)
      LV_ROOT: addr = root_entry_addr(base, root_idx);
      LV_DIR:  addr = child_entry_addr(frame, dir_idx);
      default: addr = child_entry_addr(frame, leaf_idx);
    endcase
  end
endmodule

// File: rtl/xlat_entry_eval.sv
module xlat_entry_eval
  import xlat_pkg::*;
(
  input  logic [ENT_W-1:0]  entry,
  input  walk_lv_e          lvl,
  input  logic [LIN_W-1:0]  lin,
  output logic              present,
  output logic              is_final,
  output logic [FRM_W-1:0]  frame,
  output logic [PA_W-1:0]   final_pa
);
  logic big_page;
  logic unused_bits;

  assign frame    = entry[PA_W-1:PG_SH];
  assign present  = entry[PRES_BIT];
  assign big_page = (lvl == LV_DIR) && entry[SIZE_BIT];
  assign is_final = (lvl == LV_LEAF) || big_page;
  assign final_pa = big_page ? big_page_pa(frame, lin[BIG_SH-1:0])
                             : small_page_pa(frame, lin[PG_SH-1:0]);
  assign unused_bits = ^{entry[ENT_W-1:PA_W], entry[PG_SH-1:SIZE_BIT+1],
                         entry[SIZE_BIT-1:PRES_BIT+1], lin[LIN_W-1:BIG_SH]};
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xlat_en,
  input  logic [BASE_W-1:0]   tbl_base,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LIN_W-1:0]    req_lin,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [PA_W-1:0]     mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [ENT_W-1:0]    mem_rsp_data,
  output logic                done,
  output logic [PA_W-1:0]     pa,
  output logic                fault,
  output logic [1:0]          fault_lvl,
  output logic                err
);
  walk_st_e           state_q;
  walk_lv_e           lvl_q;
  logic [LIN_W-1:0]   lin_q;
  logic [BASE_W-1:0]  base_q;
  logic [FRM_W-1:0]   frame_q;
  logic               done_q, fault_q, err_q;
  logic [PA_W-1:0]    pa_q;
  logic [1:0]         flvl_q;

  logic               walk_accept;
  logic               entry_back;
  logic               ent_present, ent_final;
  logic [FRM_W-1:0]   ent_frame;
  logic [PA_W-1:0]    ent_pa;

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_ISSUE);
  assign walk_accept   = req_valid && req_ready;
  assign entry_back    = (state_q == ST_WAIT) && mem_rsp_valid;

  xlat_addr_gen u_addr (
    .lvl   (lvl_q),
    .base  (base_q),
    .frame (frame_q),
    .lin   (lin_q),
    .addr  (mem_req_addr)
  );

  xlat_entry_eval u_eval (
    .entry    (mem_rsp_data),
    .lvl      (lvl_q),
    .lin      (lin_q),
    .present  (ent_present),
    .is_final (ent_final),
    .frame    (ent_frame),
    .final_pa (ent_pa)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= LV_ROOT;
      lin_q   <= '0;
      base_q  <= '0;
      frame_q <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      err_q   <= 1'b0;
      pa_q    <= '0;
      flvl_q  <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      err_q   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (walk_accept) begin
            if (!xlat_en) begin
              err_q <= 1'b1;
            end else begin
              lin_q   <= req_lin;
              base_q  <= tbl_base;
              lvl_q   <= LV_ROOT;
              state_q <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          if (mem_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (entry_back) begin
            if (!ent_present) begin
              fault_q <= 1'b1;
              flvl_q  <= lvl_q;
              state_q <= ST_IDLE;
            end else if (ent_final) begin
              done_q  <= 1'b1;
              pa_q    <= ent_pa;
              state_q <= ST_IDLE;
            end else begin
              frame_q <= ent_frame;
              lvl_q   <= walk_lv_e'(lvl_q + 2'd1);
              state_q <= ST_ISSUE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done      = done_q;
  assign fault     = fault_q;
  assign err       = err_q;
  assign pa        = pa_q;
  assign fault_lvl = flvl_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        xlat_en,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [35:0] mem_req_addr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_lvl,
  input logic        err,
  input logic        walk_accept
);
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, err})); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
  AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_accept && !xlat_en) |=> (!mem_req_valid && err)); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(req_valid && req_ready && !xlat_en)); // R8
  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fault_lvl != 2'd3)); // R7
  AST_READY_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault || err) |-> req_ready); // R11
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .xlat_en       (xlat_en),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .fault         (fault),
  .fault_lvl     (fault_lvl),
  .err           (err),
  .walk_accept   (walk_accept)
);

// File: tb/test_xlat_walker.sv
`timescale 1ns/1ps
module test_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b0;
  logic [26:0] tbl_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [35:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done, fault, err;
  logic [35:0] pa;
  logic [1:0]  fault_lvl;

  always #2 clk = ~clk;

  xlat_walker i_xlat_walker (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tbl_base(tbl_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .pa(pa), .fault(fault),
    .fault_lvl(fault_lvl), .err(err)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 done, 1 fault, 2 err
    logic [35:0] pa;
    logic [1:0]  lvl;
  } exp_t;

  exp_t        res_q[$];
  logic [37:0] rd_q[$];
  logic [63:0] mem [logic [35:0]];
  int checks = 0;
  int fails = 0;
  bit stall = 1'b0;
  bit finished = 1'b0;

  function automatic logic [63:0] mem_rd(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] mk_ent(input logic [23:0] frame, input bit big, input bit p);
    return {28'h8000001, frame, 4'h0, big, 6'b000110, p};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench-side walk: computes expected reads and result from the memory image
  task automatic predict(input logic [31:0] lin, input logic [26:0] base, input bit en);
    logic [35:0] a;
    logic [63:0] e;
    exp_t r;
    if (!en) begin r = '{kind: 2'd2, pa: '0, lvl: '0}; res_q.push_back(r); return; end
    a = 36'(base) * 36'd32 + 36'(lin >> 30) * 36'd8;
    rd_q.push_back({2'd0, a});
    e = mem_rd(a);
    if (e[0] == 1'b0) begin r = '{kind: 2'd1, pa: '0, lvl: 2'd0}; res_q.push_back(r); return; end
    a = 36'(e[35:12]) * 36'd4096 + 36'((lin >> 21) & 32'h1FF) * 36'd8;
    rd_q.push_back({2'd1, a});
    e = mem_rd(a);
    if (e[0] == 1'b0) begin r = '{kind: 2'd1, pa: '0, lvl: 2'd1}; res_q.push_back(r); return; end
    if (e[7]) begin
      r = '{kind: 2'd0, pa: (36'(e[35:21]) << 21) | 36'(lin & 32'h1F_FFFF), lvl: '0};
      res_q.push_back(r); return;
    end
    a = 36'(e[35:12]) * 36'd4096 + 36'((lin >> 12) & 32'h1FF) * 36'd8;
    rd_q.push_back({2'd2, a});
    e = mem_rd(a);
    if (e[0] == 1'b0) begin r = '{kind: 2'd1, pa: '0, lvl: 2'd2}; res_q.push_back(r); return; end
    r = '{kind: 2'd0, pa: (36'(e[35:12]) << 12) | 36'(lin & 32'hFFF), lvl: '0};
    res_q.push_back(r);
  endtask

  task automatic send(input logic [31:0] lin, input logic [26:0] base, input bit en);
    bit acc;
    predict(lin, base, en);
    req_valid = 1'b1; req_lin = lin; tbl_base = base; xlat_en = en;
    forever begin
      acc = req_ready;
      @(negedge clk);
      if (acc) break;
    end
    req_valid = 1'b0;
    xlat_en = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      if (res_q.size() == 0 && rd_q.size() == 0 && req_ready) break;
      @(negedge clk);
    end
    chk(res_q.size() == 0 && rd_q.size() == 0, "R10 outstanding items", res_q.size(), 0);
  endtask

  task automatic map4k(input logic [31:0] lin, input logic [26:0] base,
                       input logic [23:0] df, input logic [23:0] lf, input logic [23:0] pf);
    mem[36'(base) * 32 + 36'(lin >> 30) * 8] = mk_ent(df, 1'b1, 1'b1); // bit7 ignored at root
    mem[36'(df) * 4096 + 36'((lin >> 21) & 32'h1FF) * 8] = mk_ent(lf, 1'b0, 1'b1);
    mem[36'(lf) * 4096 + 36'((lin >> 12) & 32'h1FF) * 8] = mk_ent(pf, 1'b1, 1'b1); // bit7 ignored at leaf
  endtask

  task automatic map2m(input logic [31:0] lin, input logic [26:0] base,
                       input logic [23:0] df, input logic [23:0] bf);
    mem[36'(base) * 32 + 36'(lin >> 30) * 8] = mk_ent(df, 1'b0, 1'b1);
    mem[36'(df) * 4096 + 36'((lin >> 21) & 32'h1FF) * 8] = mk_ent(bf, 1'b1, 1'b1);
  endtask

  // Memory model and address scoreboard
  initial begin
    int cyc = 0;
    bit pend = 1'b0, hold = 1'b0;
    logic [35:0] pend_a = '0, hold_a = '0;
    logic [37:0] ex;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend) begin mem_rsp_valid = 1'b1; mem_rsp_data = mem_rd(pend_a); pend = 1'b0; end
      if (hold) begin
        chk(mem_req_valid && mem_req_addr == hold_a, "R10 held address", mem_req_addr, hold_a);
        hold = 1'b0;
      end
      mem_req_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (rst_n && mem_req_valid && mem_req_ready) begin
        if (rd_q.size() == 0) begin
          chk(1'b0, "R8 unexpected read", mem_req_addr, 0);
        end else begin
          ex = rd_q.pop_front();
          case (ex[37:36])
            2'd0:    chk(mem_req_addr == ex[35:0], "R2 root read", mem_req_addr, ex[35:0]);
            2'd1:    chk(mem_req_addr == ex[35:0], "R3 dir read", mem_req_addr, ex[35:0]);
            default: chk(mem_req_addr == ex[35:0], "R4 leaf read", mem_req_addr, ex[35:0]);
          endcase
        end
        pend = 1'b1; pend_a = mem_req_addr;
      end else if (rst_n && mem_req_valid) begin
        hold = 1'b1; hold_a = mem_req_addr;
      end
    end
  end

  // Result monitor
  initial begin
    exp_t ex;
    forever begin
      @(negedge clk);
      if (rst_n && (done || fault || err)) begin
        chk(req_ready, "R11 ready at result", req_ready, 1);
        if (res_q.size() == 0) begin
          chk(1'b0, "R9 unexpected result", {done, fault, err}, 0);
        end else begin
          ex = res_q.pop_front();
          case (ex.kind)
            2'd0: chk(done && !fault && !err && pa == ex.pa, "R5/R6 translation", pa, ex.pa);
            2'd1: chk(fault && !done && !err && fault_lvl == ex.lvl, "R7 fault level", fault_lvl, ex.lvl);
            default: chk(err && !done && !fault, "R8 disabled reject", {done, fault, err}, 1);
          endcase
        end
      end
    end
  end

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [26:0] b = 27'h0000100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !mem_req_valid && !done && !fault && !err, "R1 reset state",
        {req_ready, mem_req_valid, done, fault, err}, 5'b10000);

    // R5 4 KB walk with high frame bits
    map4k(32'h4123_4567, b, 24'h000010, 24'h000020, 24'hF12345);
    send(32'h4123_4567, b, 1'b1); drain();
    // R6 2 MB walk, low frame bits of directory entry ignored
    map2m(32'hC0A0_0FFF, b, 24'h000030, 24'h7FE1FF);
    send(32'hC0A0_0FFF, b, 1'b1); drain();
    // R6 boundary: all-ones offset, last directory slot
    map2m(32'hFFFF_FFFF, b, 24'h000030, 24'hFFFE00);
    send(32'hFFFF_FFFF, b, 1'b1); drain();
    // R8 translation off
    send(32'h4123_4567, b, 1'b0); drain();
    // R7 faults at each level
    send(32'h8000_0000, b, 1'b1); drain();
    send(32'h4800_0000, b, 1'b1); drain();
    send(32'h4120_0000, b, 1'b1); drain();
    // R2 different base and zero address
    map4k(32'h0000_0000, 27'h7FFFFFF, 24'h000040, 24'h000050, 24'h000001);
    send(32'h0000_0000, 27'h7FFFFFF, 1'b1); drain();
    // R10 stalled memory acceptance
    stall = 1'b1;
    map4k(32'h0000_1ABC, b, 24'h000060, 24'h000070, 24'hABCDEF);
    send(32'h0000_1ABC, b, 1'b1);
    send(32'hC0A0_0FFF, b, 1'b1);
    send(32'h4123_4567, b, 1'b1); drain();
    stall = 1'b0;
    // R11 back-to-back requests, next accepted on the result cycle
    send(32'h4123_4567, b, 1'b1);
    send(32'hC0A0_0FFF, b, 1'b1);
    send(32'h4120_0000, b, 1'b1);
    send(32'h0000_1ABC, b, 1'b0);
    send(32'h0000_1ABC, b, 1'b1); drain();
    repeat (4) @(negedge clk);
    report();
  end
endmodule